// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit carries out one atomic memory instruction at a time against an external single-port synchronous data memory that returns read data one cycle after the request. The caller supplies the access size, the operation code carried in the immediate, the byte address (base register plus offset, already summed), the source register value and the R0 value. The unit reads the addressed word, computes the new value, writes it back when the operation calls for it, and reports the register result. While it works it raises a lock toward the memory arbiter, so no other requester can get between its read and its write.

The immediate holds the operation. Four simple operations (add, or, and, xor) may carry a fetch modifier that returns the prior memory value to the source register. Exchange and compare-exchange always carry that modifier. Compare-exchange returns the prior value to R0 instead. Sizes other than word and double-word, misaligned addresses and unknown codes are rejected without touching memory.

Top module: `amo_unit`

## Requirements
- R1: The size input is coded 2'b00 word (32 bit), 2'b01 half-word, 2'b10 byte and 2'b11 double-word (64 bit). Only word and double-word run. Byte and half-word complete as illegal and make no memory request.
- R2: The low immediate byte selects the operation: 0x00 add, 0x40 or, 0x50 and, 0xa0 xor. The memory word at the address is replaced by (old op source).
- R3: Immediate bit 0 is the fetch modifier. With it set, a simple operation writes the pre-modification memory value into the source register. Without it, the operation writes no register.
- R4: Code 0xe1 is exchange. Memory receives the source value and the source register receives the old value.
- R5: Code 0xf1 is compare-exchange. Memory receives the source value only when the old value equals R0. Memory is left untouched on a mismatch. R0 always receives the old value and the source register is not written.
- R6: Codes 0xe0, 0xf0, any other low byte, and any set immediate bit above bit 7 complete as illegal, with no memory request and no register write.
- R7: The lock output rises in the cycle of the read request and stays high through the completion cycle, which holds the write if there is one. Every memory request falls inside the lock, and the write occurs only in the completion cycle.
- R8: In a word operation only the low 32 bits of the source and R0 take part. Address bit 2 selects the upper or lower half of the 64-bit memory word; the write mask bit 1 marks the upper half and bit 0 the lower half, and the other half is kept. All returned values are zero-extended to 64 bits.
- R9: A legal operation accepted at a clock edge issues its read in the next cycle and completes (done for one cycle) two cycles after that. An illegal one completes in the cycle after acceptance. A start while busy is ignored.
- R10: A word access needs address bits [1:0] zero and a double-word access needs bits [2:0] zero. Otherwise the operation completes as illegal.
- R11: After reset the unit is idle, with lock, request, done and busy all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation (taken only when idle) |
| size_i | input | 2 | Access size code |
| imm_i | input | IMM_W | Immediate carrying the operation code |
| addr_i | input | ADDR_W | Byte address of the target |
| src_i | input | 64 | Source register value |
| r0_i | input | 64 | R0 value (compare operand) |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Completion was a rejection |
| src_we_o | output | 1 | Write source register |
| src_wdata_o | output | 64 | Value for the source register |
| r0_we_o | output | 1 | Write R0 |
| r0_wdata_o | output | 64 | Value for R0 |
| lock_o | output | 1 | Exclusive hold on the memory for the arbiter |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W-3 | Double-word index |
| mem_wmask_o | output | 2 | Half enables for the write |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data, one cycle after the request |

## Verification
The bench builds the unit with ADDR_W set to 8, so its own memory model of 32 double-words covers the whole address space. Every location can therefore be compared against the expected image after each operation. The default IMM_W of 32 is kept, which brings immediates with stray upper bits within reach as a rejection case. Both halves of a word are written with data whose other half carries a known pattern, so a word operation that spills into the wrong half shows up at once.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int XLEN = 64;
  localparam int HALF = XLEN / 2;

  typedef enum logic [1:0] {
    SZ_W  = 2'b00,
    SZ_H  = 2'b01,
    SZ_B  = 2'b10,
    SZ_DW = 2'b11
  } amo_size_e;

  typedef enum logic [2:0] {
    K_ADD, K_OR, K_AND, K_XOR, K_XCHG, K_CMPX
  } amo_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_MOD, S_WB, S_ERR
  } amo_state_e;

  typedef struct packed {
    amo_kind_e kind;
    logic      fetch;
    logic      dw;
  } amo_cmd_t;

  function automatic logic [XLEN-1:0] amo_combine(amo_kind_e k,
                                                  logic [XLEN-1:0] a,
                                                  logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (k)
      K_ADD:   r = a + b;
      K_OR:    r = a | b;
      K_AND:   r = a & b;
      K_XOR:   r = a ^ b;
      default: r = b;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] zext_lo(logic [XLEN-1:0] v);
    return {{HALF{1'b0}}, v[HALF-1:0]};
  endfunction
endpackage

// File: rtl/amo_decoder.sv
module amo_decoder
  import amo_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [1:0]       size_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [2:0]       addr_lo_i,
  output amo_cmd_t         cmd_o,
  output logic             bad_o
);
  logic [7:0] code;
  logic       hi_nz;
  logic       code_ok;
  logic       size_ok;
  logic       align_ok;

  always_comb begin
    code        = imm_i[7:0];
    hi_nz       = |imm_i[IMM_W-1:8];
    cmd_o.fetch = code[0];
    cmd_o.dw    = (size_i == SZ_DW);
    code_ok     = 1'b1;
    case (code[7:1])
      7'h00:   cmd_o.kind = K_ADD;
      7'h20:   cmd_o.kind = K_OR;
      7'h28:   cmd_o.kind = K_AND;
      7'h50:   cmd_o.kind = K_XOR;
      7'h70: begin
        cmd_o.kind = K_XCHG;
        code_ok    = code[0];
      end
      7'h78: begin
        cmd_o.kind = K_CMPX;
        code_ok    = code[0];
      end
      default: begin
        cmd_o.kind = K_ADD;
        code_ok    = 1'b0;
      end
    endcase
    size_ok  = (size_i == SZ_W) || (size_i == SZ_DW);
    align_ok = cmd_o.dw ? (addr_lo_i == 3'b000) : (addr_lo_i[1:0] == 2'b00);
    bad_o    = hi_nz || !code_ok || !size_ok || !align_ok;
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
(
  input  amo_cmd_t        cmd_i,
  input  logic            hi_half_i,
  input  logic [XLEN-1:0] mem_word_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] r0_i,
  output logic [XLEN-1:0] old_o,
  output logic [XLEN-1:0] new_o,
  output logic            wr_o
);
  logic [XLEN-1:0] lane;
  logic [XLEN-1:0] operand;
  logic [XLEN-1:0] compare;
  logic [XLEN-1:0] result;

  always_comb begin
    lane    = hi_half_i ? (mem_word_i >> HALF) : mem_word_i;
    old_o   = cmd_i.dw ? mem_word_i : zext_lo(lane);
    operand = cmd_i.dw ? src_i : zext_lo(src_i);
    compare = cmd_i.dw ? r0_i : zext_lo(r0_i);
    result  = amo_combine(cmd_i.kind, old_o, operand);
    new_o   = cmd_i.dw ? result : {result[HALF-1:0], result[HALF-1:0]};
    wr_o    = (cmd_i.kind != K_CMPX) || (old_o == compare);
  end
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bad_i,
  output logic accept_o,
  output logic st_rd_o,
  output logic st_mod_o,
  output logic st_wb_o,
  output logic st_err_o
);
  amo_state_e state_q, state_d;

  always_comb begin
    accept_o = start_i && (state_q == S_IDLE);
    state_d  = state_q;
    case (state_q)
      S_IDLE:  if (start_i) state_d = bad_i ? S_ERR : S_RD;
      S_RD:    state_d = S_MOD;
      S_MOD:   state_d = S_WB;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign st_rd_o  = (state_q == S_RD);
  assign st_mod_o = (state_q == S_MOD);
  assign st_wb_o  = (state_q == S_WB);
  assign st_err_o = (state_q == S_ERR);
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        size_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [63:0]       src_i,
  input  logic [63:0]       r0_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              src_we_o,
  output logic [63:0]       src_wdata_o,
  output logic              r0_we_o,
  output logic [63:0]       r0_wdata_o,
  output logic              lock_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-4:0] mem_addr_o,
  output logic [1:0]        mem_wmask_o,
  output logic [63:0]       mem_wdata_o,
  input  logic [63:0]       mem_rdata_i
);
  localparam int WADDR_W = ADDR_W - 3;

  amo_cmd_t         cmd_d, cmd_q;
  logic             bad_d;
  logic             accept, st_rd, st_mod, st_wb, st_err;
  logic [WADDR_W:0] addr_q;
  logic [XLEN-1:0]  src_q, r0_q;
  logic [XLEN-1:0]  alu_old, alu_new, old_q, new_q;
  logic             alu_wr, wr_q;

  amo_decoder #(.IMM_W(IMM_W)) u_dec (
    .size_i    (size_i),
    .imm_i     (imm_i),
    .addr_lo_i (addr_i[2:0]),
    .cmd_o     (cmd_d),
    .bad_o     (bad_d)
  );

  amo_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .bad_i    (bad_d),
    .accept_o (accept),
    .st_rd_o  (st_rd),
    .st_mod_o (st_mod),
    .st_wb_o  (st_wb),
    .st_err_o (st_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '{kind: K_ADD, fetch: 1'b0, dw: 1'b0};
      addr_q <= '0;
      src_q  <= '0;
      r0_q   <= '0;
    end else if (accept) begin
      cmd_q  <= cmd_d;
      addr_q <= addr_i[ADDR_W-1:2];
      src_q  <= src_i;
      r0_q   <= r0_i;
    end
  end

  amo_alu u_alu (
    .cmd_i      (cmd_q),
    .hi_half_i  (addr_q[0]),
    .mem_word_i (mem_rdata_i),
    .src_i      (src_q),
    .r0_i       (r0_q),
    .old_o      (alu_old),
    .new_o      (alu_new),
    .wr_o       (alu_wr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q <= '0;
      new_q <= '0;
      wr_q  <= 1'b0;
    end else if (st_mod) begin
      old_q <= alu_old;
      new_q <= alu_new;
      wr_q  <= alu_wr;
    end
  end

  assign busy_o      = st_rd || st_mod || st_wb || st_err;
  assign lock_o      = st_rd || st_mod || st_wb;
  assign done_o      = st_wb || st_err;
  assign illegal_o   = st_err;
  assign mem_req_o   = st_rd || (st_wb && wr_q);
  assign mem_we_o    = st_wb && wr_q;
  assign mem_addr_o  = addr_q[WADDR_W:1];
  assign mem_wmask_o = cmd_q.dw ? 2'b11 : (addr_q[0] ? 2'b10 : 2'b01);
  assign mem_wdata_o = new_q;
  assign src_we_o    = st_wb && cmd_q.fetch && (cmd_q.kind != K_CMPX);
  assign r0_we_o     = st_wb && (cmd_q.kind == K_CMPX);
  assign src_wdata_o = old_q;
  assign r0_wdata_o  = old_q;
endmodule

module amo_chk (
  input logic clk,
  input logic rst_n,
  input logic done_o,
  input logic illegal_o,
  input logic src_we_o,
  input logic r0_we_o,
  input logic lock_o,
  input logic mem_req_o,
  input logic mem_we_o
);
  AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> lock_o); // R7
  AST_LOCK_OPENS_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> (mem_req_o && !mem_we_o)); // R7
  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !done_o) |=> lock_o); // R7
  AST_WRITE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (done_o && !illegal_o)); // R7
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!mem_req_o && !src_we_o && !r0_we_o && !lock_o)); // R6
  AST_ONE_RESULT_REG: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_we_o && r0_we_o)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_READ_TWO_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !illegal_o) |-> $past(mem_req_o && !mem_we_o, 2)); // R9
endmodule

bind amo_unit amo_chk u_chk (.*);

// File: tb/tb_amo_unit.sv
`timescale 1ns/1ps
module tb_amo_unit;
  localparam int AW = 8;
  localparam int NW = 1 << (AW - 3);
  localparam logic [63:0] M32 = 64'h0000_0000_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [31:0] imm_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [63:0] src_i = '0, r0_i = '0;
  logic        busy_o, done_o, illegal_o, src_we_o, r0_we_o, lock_o;
  logic        mem_req_o, mem_we_o;
  logic [63:0] src_wdata_o, r0_wdata_o, mem_wdata_o;
  logic [AW-4:0] mem_addr_o;
  logic [1:0]  mem_wmask_o;
  logic [63:0] mem_rdata_i = '0;

  logic [63:0] mem [NW];
  logic [63:0] exp_mem [NW];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  amo_unit #(.ADDR_W(AW), .IMM_W(32)) dut (.*);

  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) begin
        if (mem_wmask_o[0]) mem[mem_addr_o][31:0]  <= mem_wdata_o[31:0];
        if (mem_wmask_o[1]) mem[mem_addr_o][63:32] <= mem_wdata_o[63:32];
      end else begin
        mem_rdata_i <= mem[mem_addr_o];
      end
    end
  end

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic run_op(string tag, logic [1:0] sz, logic [31:0] imm,
                        logic [7:0] addr, logic [63:0] src, logic [63:0] r0, bit hold);
    bit dw, legal, wr, sw, rw;
    int w;
    logic [7:0] c;
    logic [63:0] word, old, opd, cmp, res;
    dw = (sz == 2'b11);
    w  = int'(addr[7:3]);
    c  = imm[7:0];
    legal = (sz == 2'b00 || sz == 2'b11) && (imm[31:8] == 0)
            && (dw ? addr[2:0] == 0 : addr[1:0] == 0)
            && (c inside {8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51,
                          8'ha0, 8'ha1, 8'he1, 8'hf1});
    word = exp_mem[w];
    old  = dw ? word : (addr[2] ? (word >> 32) : (word & M32));
    opd  = dw ? src : (src & M32);
    cmp  = dw ? r0 : (r0 & M32);
    wr   = 1'b1;
    case ({c[7:1], 1'b0})
      8'h00:   res = old + opd;
      8'h40:   res = old | opd;
      8'h50:   res = old & opd;
      8'ha0:   res = old ^ opd;
      8'he0:   res = opd;
      8'hf0: begin res = opd; wr = (old == cmp); end
      default: res = '0;
    endcase
    if (!dw) res = res & M32;
    sw = c[0] && (c != 8'hf1);
    rw = (c == 8'hf1);

    @(negedge clk);
    start_i = 1'b1; size_i = sz; imm_i = imm; addr_i = addr; src_i = src; r0_i = r0;
    @(negedge clk);
    if (!legal) begin
      chk({tag, " illegal flag"}, {62'd0, done_o, illegal_o}, 64'd3);
      chk({tag, " no request"}, {62'd0, mem_req_o, lock_o}, 64'd0);
      chk({tag, " no reg write"}, {62'd0, src_we_o, r0_we_o}, 64'd0);
      start_i = 1'b0;
      @(negedge clk);
      chk("R9 done after reject", {63'd0, done_o | busy_o}, 64'd0);
      chk({tag, " memory kept"}, mem[w], exp_mem[w]);
      return;
    end
    chk("R7 read under lock", {61'd0, lock_o, mem_req_o, mem_we_o}, 64'd6);
    chk("R7 read index", 64'(mem_addr_o), 64'(w));
    chk("R9 no early done", 64'(done_o), 64'd0);
    if (!hold) start_i = 1'b0;
    @(negedge clk);
    chk("R7 lock held idle", {62'd0, lock_o, mem_req_o}, 64'd2);
    start_i = 1'b0;
    @(negedge clk);
    chk("R9 done", {62'd0, done_o, illegal_o}, 64'd2);
    chk("R7 lock at done", 64'(lock_o), 64'd1);
    chk({tag, " write decision"}, {62'd0, mem_req_o, mem_we_o}, {62'd0, wr, wr});
    chk({tag, " reg enables"}, {62'd0, src_we_o, r0_we_o}, {62'd0, sw, rw});
    if (sw) chk({tag, " src value"}, src_wdata_o, old);
    if (rw) chk({tag, " r0 value"}, r0_wdata_o, old);
    if (wr) chk("R8 write mask", 64'(mem_wmask_o),
                dw ? 64'd3 : (addr[2] ? 64'd2 : 64'd1));
    if (wr) begin
      if (dw)           exp_mem[w] = res;
      else if (addr[2]) exp_mem[w] = {res[31:0], word[31:0]};
      else              exp_mem[w] = {word[63:32], res[31:0]};
    end
    @(negedge clk);
    chk("R7 lock released", {62'd0, lock_o, busy_o}, 64'd0);
    chk({tag, " memory"}, mem[w], exp_mem[w]);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      mem[i] = {32'h1357_0000 + 32'(i), 32'h8000_0000 + 32'(i * 3)};
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk("R11 reset idle", {59'd0, lock_o, mem_req_o, done_o, busy_o, illegal_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle after reset", {62'd0, lock_o, busy_o}, 64'd0);

    run_op("R2", 2'b11, 32'h00, 8'h08, 64'h0000_0001_0000_0001, 0, 0);
    run_op("R3", 2'b11, 32'h01, 8'h10, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    run_op("R8", 2'b00, 32'h41, 8'h14, 64'hDEAD_BEEF_0F0F_00F0, 0, 0);
    run_op("R2", 2'b00, 32'h50, 8'h20, 64'h1234_5678_00FF_FF00, 0, 0);
    run_op("R3", 2'b11, 32'ha1, 8'h28, 64'h5555_AAAA_5555_AAAA, 0, 0);
    run_op("R8", 2'b00, 32'h01, 8'h30, 64'hABCD_0000_9000_0000, 0, 0);
    run_op("R4", 2'b11, 32'he1, 8'h38, 64'h0123_4567_89AB_CDEF, 0, 0);
    run_op("R4", 2'b00, 32'he1, 8'h44, 64'hFFFF_0000_CAFE_F00D, 0, 0);
    run_op("R5", 2'b11, 32'hf1, 8'h48, 64'h1111_2222_3333_4444, exp_mem[9], 0);
    run_op("R5", 2'b11, 32'hf1, 8'h50, 64'h7777_7777_7777_7777, ~exp_mem[10], 0);
    run_op("R5", 2'b00, 32'hf1, 8'h58, 64'h0000_0000_4242_4242,
           {32'hFFFF_FFFF, exp_mem[11][31:0]}, 0);
    run_op("R5", 2'b00, 32'hf1, 8'h5C, 64'h9, 64'h0, 0);
    run_op("R9", 2'b11, 32'h40, 8'h60, 64'h00F0_0000_0000_000F, 0, 1);
    run_op("R1", 2'b10, 32'h00, 8'h68, 64'h5, 0, 0);
    run_op("R1", 2'b01, 32'h01, 8'h68, 64'h5, 0, 0);
    run_op("R6", 2'b11, 32'he0, 8'h70, 64'h5, 0, 0);
    run_op("R6", 2'b11, 32'hf0, 8'h70, 64'h5, exp_mem[14], 0);
    run_op("R6", 2'b00, 32'h30, 8'h70, 64'h5, 0, 0);
    run_op("R6", 2'b11, 32'h100, 8'h70, 64'h5, 0, 0);
    run_op("R10", 2'b00, 32'h00, 8'h72, 64'h5, 0, 0);
    run_op("R10", 2'b11, 32'h00, 8'h74, 64'h5, 0, 0);
    run_op("R2", 2'b11, 32'ha0, 8'hF8, 64'hFFFF_FFFF_0000_0000, 0, 0);

    for (int i = 0; i < NW; i++) chk("R8 final image", mem[i], exp_mem[i]);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule